// File: doc/BRIEF.md
# Pair-Capable Register File

This block is the working register store of a small 8-bit processor core: thirty-two byte-wide registers, two combinational byte read ports and one write path. Besides plain byte writes, it carries out word operations on aligned register pairs. An aligned pair is an even register holding the low byte and the odd register above it holding the high byte. The word operations are a pair copy between any two aligned pairs, and a 16-bit add or subtract of a small unsigned immediate on the four highest pairs.

The request decoder flags requests whose operands are not allowed: odd pair indices, word arithmetic outside the top four pairs, immediate-class byte writes aimed below register 16, and reserved operation codes. A flagged request writes nothing. The three highest pairs are also driven out as 16-bit address pointers. A separate port lets a multiplier deposit its 16-bit product into registers 1:0, and this write wins over any other write to those registers. A program-memory byte load goes to register 0 unless an explicit destination is given.

The instruction decoder outside this block supplies an operation code, register indices and, for byte operations, the byte already computed by the ALU. The block returns the flagged-illegal indication and, for word arithmetic, the 16-bit result with carry/borrow and zero bits.

Top module: `rfp_top`

## Requirements
- R1: Reads on both ports are combinational and return the value held before the current edge, even when a write to that register is pending. A synchronous active-high reset clears all 32 registers to zero.
- R2: Operation code 0 (plain byte write) writes `wrByte` to any register `dstIdx` from 0 to 31.
- R3: Operation code 1 (immediate-class byte write) writes `wrByte` only when `dstIdx` is 16 or above. For a lower destination, `illegalOp` is high and no register changes.
- R4: Operation code 2 (pair copy) copies the source pair to the destination pair. The low byte comes from the even register `srcIdx` and the high byte from `srcIdx`+1, and both are written to `dstIdx` and `dstIdx`+1. If either index is odd, `illegalOp` is high and nothing is written.
- R5: Operation codes 3 (word add) and 4 (word subtract) apply the 6-bit unsigned `imm` to the pair at `dstIdx`, wrap modulo 65536, and write the result back. They are legal only for `dstIdx` of 24, 26, 28 or 30. Any other base raises `illegalOp` and writes nothing.
- R6: During a legal word add or subtract, `wordResult` shows the 16-bit result, `wordCarry` shows the carry out (add) or borrow (subtract), and `wordZero` is high when the result is zero. At all other times all three are zero.
- R7: `ptrX` is registers 27:26, `ptrY` is 29:28 and `ptrZ` is 31:30, each with the high byte at the odd register.
- R8: When `mulValid` is high, `mulResult` is written to registers 1 (high byte) and 0 (low byte) at the edge. It takes priority over any other write to those registers in the same cycle and stays until overwritten.
- R9: Operation code 5 (program-memory byte load) writes `wrByte` to register 0 when `pmemExplicit` is 0, and to `dstIdx` when it is 1.
- R10: Operation codes 6 and 7 are reserved. They raise `illegalOp` and write nothing. `illegalOp` is low whenever `opValid` is low, and a flagged request changes no register.
- R11: Both bytes of a pair write are committed on the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Read port A register index |
| rdDataA | output | 8 | Read port A data |
| rdAddrB | input | 5 | Read port B register index |
| rdDataB | output | 8 | Read port B data |
| opValid | input | 1 | Request valid this cycle |
| opCode | input | 3 | Operation code (0..7, see requirements) |
| dstIdx | input | 5 | Destination register or pair base |
| srcIdx | input | 5 | Source pair base for pair copy |
| wrByte | input | 8 | Byte to write for byte operations |
| imm | input | 6 | Unsigned word immediate |
| pmemExplicit | input | 1 | Program-memory load uses `dstIdx` when high |
| mulValid | input | 1 | Write product to registers 1:0 |
| mulResult | input | 16 | Product, high byte to register 1 |
| illegalOp | output | 1 | Current request has an illegal operand |
| wordResult | output | 16 | Word add/subtract result |
| wordCarry | output | 1 | Carry out or borrow of word arithmetic |
| wordZero | output | 1 | Word result is zero |
| ptrX | output | 16 | Registers 27:26 |
| ptrY | output | 16 | Registers 29:28 |
| ptrZ | output | 16 | Registers 31:30 |

## Verification
On every cycle, the assertions check that illegal operands are flagged and that flagged requests leave the pointers untouched. They also check that the word-result outputs rest at zero when no word arithmetic is legal, that a product always lands in registers 1:0 over any competing write, and that a legal add on the Y base moves `ptrY` to the shown result. The bench scenarios are what show the actual register contents after copies between overlapping and arbitrary pairs, read-old-data behaviour during a write, wrap-around with carry and borrow at 0xFFFF and 0x0000, and the default and explicit targets of the program-memory load.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 32;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int WORD_W   = 2 * DATA_W;

  typedef enum logic [2:0] {
    OP_BYTE      = 3'd0,
    OP_BYTE_IMM  = 3'd1,
    OP_PAIR_MOVE = 3'd2,
    OP_PAIR_ADD  = 3'd3,
    OP_PAIR_SUB  = 3'd4,
    OP_PMEM      = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } rfpOp_e;

  typedef enum logic [1:0] {
    SEL_BYTE  = 2'd0,
    SEL_MOVE  = 2'd1,
    SEL_ARITH = 2'd2
  } rfpSel_e;

  // Strobes handed from the request checker to the storage datapath
  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic [ADDR_W-1:0] loIdx;
    logic [ADDR_W-1:0] hiIdx;
    logic [ADDR_W-2:0] srcPair;
    rfpSel_e           dataSel;
    logic              doArith;
    logic              doSub;
    logic              illegal;
  } rfpStrobe_t;

endpackage

// File: rtl/rfp_ctrl.sv
module rfp_ctrl
  import rfp_pkg::*;
#(
  parameter int LOW_IMM_LIMIT = 16,
  parameter int WORD_BASE     = 24
) (
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] dstIdx,
  input  logic [ADDR_W-1:0] srcIdx,
  input  logic              pmemExplicit,
  output rfpStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] IMM_MIN  = ADDR_W'(LOW_IMM_LIMIT);
  localparam logic [ADDR_W-1:0] WORD_MIN = ADDR_W'(WORD_BASE);

  rfpOp_e            op;
  logic              legal;
  logic              isPair;
  logic              isArith;
  logic [ADDR_W-1:0] byteTarget;

  assign op = rfpOp_e'(opCode);

  always_comb begin
    legal      = 1'b0;
    byteTarget = dstIdx;
    case (op)
      OP_BYTE:                  legal = 1'b1;
      OP_BYTE_IMM:              legal = (dstIdx >= IMM_MIN);
      OP_PAIR_MOVE:             legal = !dstIdx[0] && !srcIdx[0];
      OP_PAIR_ADD, OP_PAIR_SUB: legal = !dstIdx[0] && (dstIdx >= WORD_MIN);
      OP_PMEM: begin
        legal      = 1'b1;
        byteTarget = pmemExplicit ? dstIdx : '0;
      end
      default:                  legal = 1'b0;
    endcase
  end

  assign isArith = (op == OP_PAIR_ADD) || (op == OP_PAIR_SUB);
  assign isPair  = isArith || (op == OP_PAIR_MOVE);

  always_comb begin
    strb.illegal = opValid && !legal;
    strb.wrLo    = opValid && legal;
    strb.wrHi    = opValid && legal && isPair;
    strb.loIdx   = isPair ? {dstIdx[ADDR_W-1:1], 1'b0} : byteTarget;
    strb.hiIdx   = {dstIdx[ADDR_W-1:1], 1'b1};
    strb.srcPair = srcIdx[ADDR_W-1:1];
    strb.doArith = opValid && legal && isArith;
    strb.doSub   = (op == OP_PAIR_SUB);
    if (isArith)                strb.dataSel = SEL_ARITH;
    else if (op == OP_PAIR_MOVE) strb.dataSel = SEL_MOVE;
    else                        strb.dataSel = SEL_BYTE;
  end

endmodule

// File: rtl/rfp_datapath.sv
module rfp_datapath
  import rfp_pkg::*;
#(
  parameter int IMM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  rfpStrobe_t        strb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [IMM_W-1:0]  imm,
  input  logic              mulValid,
  input  logic [WORD_W-1:0] mulResult,
  output logic [WORD_W-1:0] wordResult,
  output logic              wordCarry,
  output logic              wordZero,
  output logic [WORD_W-1:0] ptrX,
  output logic [WORD_W-1:0] ptrY,
  output logic [WORD_W-1:0] ptrZ,
  output logic [WORD_W-1:0] lowPair
);

  localparam int X_BASE = NUM_REGS - 6;
  localparam int Y_BASE = NUM_REGS - 4;
  localparam int Z_BASE = NUM_REGS - 2;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] dstWord;
  logic [WORD_W:0]   arith;
  logic [WORD_W:0]   immExt;
  logic [DATA_W-1:0] loData;
  logic [DATA_W-1:0] hiData;

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  assign srcWord = {regs[{strb.srcPair, 1'b1}], regs[{strb.srcPair, 1'b0}]};
  assign dstWord = {regs[strb.hiIdx], regs[strb.loIdx]};
  assign immExt  = (WORD_W + 1)'(imm);

  always_comb begin
    if (strb.doSub) arith = {1'b0, dstWord} - immExt;
    else            arith = {1'b0, dstWord} + immExt;
  end

  assign wordResult = strb.doArith ? arith[WORD_W-1:0] : '0;
  assign wordCarry  = strb.doArith && arith[WORD_W];
  assign wordZero   = strb.doArith && (arith[WORD_W-1:0] == '0);

  always_comb begin
    case (strb.dataSel)
      SEL_MOVE:  {hiData, loData} = srcWord;
      SEL_ARITH: {hiData, loData} = arith[WORD_W-1:0];
      default:   {hiData, loData} = {wrByte, wrByte};
    endcase
  end

  // All writes, product port first, commit on one edge
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)                                         regs[i] <= '0;
      else if (mulValid && i == 0)                     regs[i] <= mulResult[DATA_W-1:0];
      else if (mulValid && i == 1)                     regs[i] <= mulResult[WORD_W-1:DATA_W];
      else if (strb.wrLo && strb.loIdx == ADDR_W'(i))  regs[i] <= loData;
      else if (strb.wrHi && strb.hiIdx == ADDR_W'(i))  regs[i] <= hiData;
    end
  end

  assign ptrX    = {regs[X_BASE + 1], regs[X_BASE]};
  assign ptrY    = {regs[Y_BASE + 1], regs[Y_BASE]};
  assign ptrZ    = {regs[Z_BASE + 1], regs[Z_BASE]};
  assign lowPair = {regs[1], regs[0]};

endmodule

// File: rtl/rfp_top.sv
module rfp_top
  import rfp_pkg::*;
#(
  parameter int IMM_W         = 6,
  parameter int LOW_IMM_LIMIT = 16,
  parameter int WORD_BASE     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] dstIdx,
  input  logic [ADDR_W-1:0] srcIdx,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [IMM_W-1:0]  imm,
  input  logic              pmemExplicit,
  input  logic              mulValid,
  input  logic [WORD_W-1:0] mulResult,
  output logic              illegalOp,
  output logic [WORD_W-1:0] wordResult,
  output logic              wordCarry,
  output logic              wordZero,
  output logic [WORD_W-1:0] ptrX,
  output logic [WORD_W-1:0] ptrY,
  output logic [WORD_W-1:0] ptrZ
);

  rfpStrobe_t        strb;
  logic [WORD_W-1:0] lowPair;

  rfp_ctrl #(
    .LOW_IMM_LIMIT(LOW_IMM_LIMIT),
    .WORD_BASE    (WORD_BASE)
  ) u_ctrl (
    .opValid     (opValid),
    .opCode      (opCode),
    .dstIdx      (dstIdx),
    .srcIdx      (srcIdx),
    .pmemExplicit(pmemExplicit),
    .strb        (strb)
  );

  rfp_datapath #(
    .IMM_W(IMM_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rdAddrA   (rdAddrA),
    .rdAddrB   (rdAddrB),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .strb      (strb),
    .wrByte    (wrByte),
    .imm       (imm),
    .mulValid  (mulValid),
    .mulResult (mulResult),
    .wordResult(wordResult),
    .wordCarry (wordCarry),
    .wordZero  (wordZero),
    .ptrX      (ptrX),
    .ptrY      (ptrY),
    .ptrZ      (ptrZ),
    .lowPair   (lowPair)
  );

  assign illegalOp = strb.illegal;

endmodule

// File: rtl/rfp_checker.sv
module rfp_checker
  import rfp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [ADDR_W-1:0] dstIdx,
  input logic [ADDR_W-1:0] srcIdx,
  input logic              mulValid,
  input logic [WORD_W-1:0] mulResult,
  input logic              illegalOp,
  input logic [WORD_W-1:0] wordResult,
  input logic              wordCarry,
  input logic              wordZero,
  input logic [WORD_W-1:0] ptrX,
  input logic [WORD_W-1:0] ptrY,
  input logic [WORD_W-1:0] ptrZ,
  input logic [WORD_W-1:0] lowPair
);

  logic isArith;
  assign isArith = (opCode == 3'd3) || (opCode == 3'd4);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ptrX == '0) && (ptrY == '0) && (ptrZ == '0) && (lowPair == '0));

  assert_low_imm_flagged_R3: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd1 && dstIdx < 5'd16) |-> illegalOp);

  assert_odd_pair_flagged_R4: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd2 && (dstIdx[0] || srcIdx[0])) |-> illegalOp);

  assert_word_base_flagged_R5: assert property (@(posedge clk) disable iff (rst)
    (opValid && isArith && (dstIdx[0] || dstIdx < 5'd24)) |-> illegalOp);

  assert_word_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !(opValid && isArith && !illegalOp) |-> (wordResult == '0) && !wordCarry && !wordZero);

  assert_y_update_R7: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 3'd3 && dstIdx == 5'd28 && !illegalOp) |=> ptrY == $past(wordResult));

  assert_product_wins_R8: assert property (@(posedge clk) disable iff (rst)
    mulValid |=> lowPair == $past(mulResult));

  assert_idle_not_flagged_R10: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> !illegalOp);

  assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (opValid && illegalOp) |=> $stable(ptrX) && $stable(ptrY) && $stable(ptrZ));

endmodule

bind rfp_top rfp_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .opValid   (opValid),
  .opCode    (opCode),
  .dstIdx    (dstIdx),
  .srcIdx    (srcIdx),
  .mulValid  (mulValid),
  .mulResult (mulResult),
  .illegalOp (illegalOp),
  .wordResult(wordResult),
  .wordCarry (wordCarry),
  .wordZero  (wordZero),
  .ptrX      (ptrX),
  .ptrY      (ptrY),
  .ptrZ      (ptrZ),
  .lowPair   (lowPair)
);

// File: tb/rfp_top_bench.sv
module rfp_top_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rdAddrA, rdAddrB;
  logic [7:0]  rdDataA, rdDataB;
  logic        opValid;
  logic [2:0]  opCode;
  logic [4:0]  dstIdx, srcIdx;
  logic [7:0]  wrByte;
  logic [5:0]  imm;
  logic        pmemExplicit;
  logic        mulValid;
  logic [15:0] mulResult;
  logic        illegalOp;
  logic [15:0] wordResult;
  logic        wordCarry, wordZero;
  logic [15:0] ptrX, ptrY, ptrZ;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [32];

  always #10 clk = ~clk;  // 50 MHz

  rfp_top u_rfp_top (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .opValid(opValid), .opCode(opCode), .dstIdx(dstIdx), .srcIdx(srcIdx),
    .wrByte(wrByte), .imm(imm), .pmemExplicit(pmemExplicit),
    .mulValid(mulValid), .mulResult(mulResult),
    .illegalOp(illegalOp), .wordResult(wordResult),
    .wordCarry(wordCarry), .wordZero(wordZero),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legalOf(input logic [2:0] op, input logic [4:0] d, input logic [4:0] s);
    case (op)
      3'd0, 3'd5: return 1'b1;
      3'd1:       return d >= 5'd16;
      3'd2:       return !d[0] && !s[0];
      3'd3, 3'd4: return !d[0] && d >= 5'd24;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [16:0] wordOf(input logic [2:0] op, input logic [15:0] w,
                                         input logic [5:0] i);
    if (op == 3'd3) return {1'b0, w} + {11'b0, i};
    return {1'b0, w} - {11'b0, i};
  endfunction

  function automatic string reqOf(input logic [2:0] op, input logic pe);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return pe ? "R9" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic readCheck(input logic [4:0] a, input logic [4:0] b, input string req);
    rdAddrA = a;
    rdAddrB = b;
    #1;
    check(rdDataA == model[a], req, $sformatf("read r%0d", a), rdDataA, model[a]);
    check(rdDataB == model[b], req, $sformatf("read r%0d", b), rdDataB, model[b]);
  endtask

  task automatic ptrCheck();
    check(ptrX == {model[27], model[26]}, "R7", "ptrX", ptrX, {model[27], model[26]});
    check(ptrY == {model[29], model[28]}, "R7", "ptrY", ptrY, {model[29], model[28]});
    check(ptrZ == {model[31], model[30]}, "R7", "ptrZ", ptrZ, {model[31], model[30]});
  endtask

  task automatic doOp(input logic v, input logic [2:0] op, input logic [4:0] d,
                      input logic [4:0] s, input logic [7:0] b, input logic [5:0] i,
                      input logic pe, input logic mv, input logic [15:0] mr);
    bit lg;
    logic [16:0] w;
    logic [15:0] srcW;
    logic [4:0] tgt;
    string rq;
    @(negedge clk);
    opValid = v; opCode = op; dstIdx = d; srcIdx = s; wrByte = b; imm = i;
    pmemExplicit = pe; mulValid = mv; mulResult = mr;
    rdAddrA = d; rdAddrB = {d[4:1], 1'b1};
    #2;
    rq = reqOf(op, pe);
    lg = legalOf(op, d, s);
    check(illegalOp == (v && !lg), v ? rq : "R10", "illegalOp", illegalOp, v && !lg);
    // R1: old data visible before the edge
    check(rdDataA == model[d], "R1", "read before edge", rdDataA, model[d]);
    w = wordOf(op, {model[{d[4:1], 1'b1}], model[{d[4:1], 1'b0}]}, i);
    if (v && lg && (op == 3'd3 || op == 3'd4)) begin
      check(wordResult == w[15:0], "R6", "wordResult", wordResult, w[15:0]);
      check(wordCarry == w[16], "R6", "wordCarry", wordCarry, w[16]);
      check(wordZero == (w[15:0] == 16'h0), "R6", "wordZero", wordZero, w[15:0] == 16'h0);
    end else begin
      check(wordResult == 16'h0 && !wordCarry && !wordZero, "R6", "word outputs idle",
            {wordCarry, wordZero, wordResult}, 0);
    end
    @(posedge clk);
    srcW = {model[{s[4:1], 1'b1}], model[{s[4:1], 1'b0}]};
    if (v && lg) begin
      case (op)
        3'd0, 3'd1: model[d] = b;
        3'd2: begin model[{d[4:1], 1'b0}] = srcW[7:0]; model[{d[4:1], 1'b1}] = srcW[15:8]; end
        3'd3, 3'd4: begin model[d] = w[7:0]; model[d + 5'd1] = w[15:8]; end
        default: begin tgt = pe ? d : 5'd0; model[tgt] = b; end
      endcase
    end
    if (mv) begin model[0] = mr[7:0]; model[1] = mr[15:8]; end
    #2;
    opValid = 1'b0; mulValid = 1'b0;
    ptrCheck();
    readCheck({d[4:1], 1'b0}, {d[4:1], 1'b1}, (op == 3'd2 || op == 3'd3 || op == 3'd4) ? "R11" : rq);
    readCheck(5'd0, 5'd1, mv ? "R8" : "R8");
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; opValid = 1'b0; opCode = '0; dstIdx = '0; srcIdx = '0; wrByte = '0;
    imm = '0; pmemExplicit = 1'b0; mulValid = 1'b0; mulResult = '0;
    rdAddrA = '0; rdAddrB = '0;
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int k = 0; k < 32; k += 2) readCheck(5'(k), 5'(k + 1), "R1");
    ptrCheck();

    // Fill every register via byte writes (R2)
    for (int k = 0; k < 32; k++) doOp(1, 3'd0, 5'(k), 0, 8'($urandom), 0, 0, 0, 0);

    // R3 boundaries
    doOp(1, 3'd1, 5'd15, 0, 8'hA5, 0, 0, 0, 0);
    doOp(1, 3'd1, 5'd16, 0, 8'h5A, 0, 0, 0, 0);
    // R4 odd source / destination, and a legal copy into Z
    doOp(1, 3'd2, 5'd4, 5'd3, 0, 0, 0, 0, 0);
    doOp(1, 3'd2, 5'd5, 5'd2, 0, 0, 0, 0, 0);
    doOp(1, 3'd2, 5'd30, 5'd0, 0, 0, 0, 0, 0);
    // R5/R6 wrap: Z = 0xFFFF + 1 -> 0 carry; X = 0x0000 - 1 -> borrow
    doOp(1, 3'd0, 5'd30, 0, 8'hFF, 0, 0, 0, 0);
    doOp(1, 3'd0, 5'd31, 0, 8'hFF, 0, 0, 0, 0);
    doOp(1, 3'd3, 5'd30, 0, 0, 6'd1, 0, 0, 0);
    doOp(1, 3'd0, 5'd26, 0, 8'h00, 0, 0, 0, 0);
    doOp(1, 3'd0, 5'd27, 0, 8'h00, 0, 0, 0, 0);
    doOp(1, 3'd4, 5'd26, 0, 0, 6'd1, 0, 0, 0);
    doOp(1, 3'd4, 5'd24, 0, 0, 6'd63, 0, 0, 0);
    doOp(1, 3'd3, 5'd28, 0, 0, 6'd63, 0, 0, 0);
    doOp(1, 3'd3, 5'd22, 0, 0, 6'd2, 0, 0, 0);
    doOp(1, 3'd4, 5'd25, 0, 0, 6'd2, 0, 0, 0);
    // R8 product wins over a pair copy into r1:r0 and a byte write to r1
    doOp(1, 3'd2, 5'd0, 5'd30, 0, 0, 0, 1, 16'hBEEF);
    doOp(1, 3'd0, 5'd1, 0, 8'h11, 0, 0, 1, 16'h1234);
    doOp(1, 3'd0, 5'd20, 0, 8'h77, 0, 0, 0, 0);  // r1:r0 persists
    // R9 program-memory load, default and explicit
    doOp(1, 3'd5, 5'd9, 0, 8'hC3, 0, 0, 0, 0);
    doOp(1, 3'd5, 5'd9, 0, 8'h3C, 0, 1, 0, 0);
    // R10 reserved codes and idle requests
    doOp(1, 3'd6, 5'd26, 0, 8'h99, 0, 0, 0, 0);
    doOp(1, 3'd7, 5'd30, 0, 8'h99, 0, 0, 0, 0);
    doOp(0, 3'd0, 5'd28, 0, 8'h99, 0, 0, 0, 0);

    // Constrained random traffic
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      logic [4:0] d, s;
      op = 3'($urandom_range(0, 7));
      d  = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(24, 31)) : 5'($urandom);
      s  = 5'($urandom);
      doOp($urandom_range(0, 7) != 0, op, d, s, 8'($urandom), 6'($urandom),
           1'($urandom), $urandom_range(0, 7) == 0, 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule